// File: doc/BRIEF.md
# Line-Draw Pixel Address Sequencer

This block steps a blitter's memory traffic through a line-drawing operation. Each pixel step has a fixed four-slot rhythm: a read of the destination word through the C channel, a true idle slot, a write of the modified word, and a second true idle slot. The first write of a line goes to the D pointer latched at start. Every later write reuses the C pointer, which walks the line: it moves by the C modulo on a row step and by one word on a column step. The octant logic and the Bresenham error term live elsewhere and supply the per-step direction controls.

The block also carries the A pointer, which advances by a signed increment once per step only while the A channel is enabled. In line mode the D modulo and the D enable bit have no effect. A horizontal size other than two is reported on a warning flag. Memory slots wait for a free bus, while idle slots never do. After the programmed number of steps the block raises done.

Top module: `line_addr_seq`

## Requirements
- R1: With the bus always free, each step takes exactly four cycles in this order: one read request cycle, one cycle with no request, one write request cycle, one cycle with no request. Each step makes exactly one read and one write.
- R2: A read request (req_o=1, wr_o=0) carries the current C pointer on addr_o. The C pointer starts at c_ptr_in, which is latched at start.
- R3: The first write of a line (req_o=1, wr_o=1) carries d_ptr_in as latched at start. Every later write carries the current C pointer.
- R4: When a write is granted, the C pointer changes by c_mod (two's complement) if row_step=1, plus +1 if word_step=1 and word_dec=0, or -1 if word_step=1 and word_dec=1. The step controls are sampled at the grant edge, and d_mod has no effect.
- R5: d_en has no effect: a write is requested in every step whatever its value.
- R6: a_ptr_o loads a_ptr_in at start. With a_en=1 it adds a_inc once per step. With a_en=0 it holds its value.
- R7: A request with bus_free=0 holds req_o, wr_o and addr_o unchanged into the next cycle. An idle slot advances whatever the value of bus_free.
- R8: After num_steps steps the cycle after the final idle slot shows done_o=1, busy_o=0 and req_o=0, and done_o stays high until the next start. When num_steps=0, done_o is high the cycle after start and no request occurs. Reset clears done_o, busy_o and req_o.
- R9: At start, hsize_warn_o becomes 1 if hsize is not 2 and 0 if it is 2. It holds that value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a line; ignored while busy |
| num_steps | input | CW | Number of pixel steps in the line |
| hsize | input | HW | Programmed horizontal size, expected to be 2 |
| c_ptr_in | input | AW | Initial C pointer |
| d_ptr_in | input | AW | Target of the first write |
| a_ptr_in | input | AW | Initial A pointer |
| c_mod | input | AW | Signed row step of the C pointer |
| d_mod | input | AW | D modulo, no effect in this mode |
| a_inc | input | AW | Signed per-step A pointer increment |
| a_en | input | 1 | A channel enable; gates A pointer updates |
| d_en | input | 1 | D channel enable, no effect in this mode |
| row_step | input | 1 | Apply c_mod at this step's write |
| word_step | input | 1 | Move one word at this step's write |
| word_dec | input | 1 | Word move direction: 1 decrements |
| bus_free | input | 1 | Bus available; grants a pending request |
| req_o | output | 1 | Memory request this cycle |
| wr_o | output | 1 | Request is a write |
| addr_o | output | AW | Request address |
| a_ptr_o | output | AW | Current A pointer |
| busy_o | output | 1 | Line in progress |
| done_o | output | 1 | Line completed |
| hsize_warn_o | output | 1 | Horizontal size was not 2 at start |

## Verification
The assertions check on every cycle the slot rhythm after each granted read and write. They also check that a refused request stays frozen, that the A pointer stays put while its channel is off, and that the block is quiet once done. Only the bench scenarios can show that the addresses are right. That means the first write going to the D pointer and later writes following the C pointer's modulo and word walk with d_mod and d_en changed. The bench scenarios also cover the exact count of steps before done and the A pointer's final value for each enable setting.

// File: rtl/lds_pkg.sv
package lds_pkg;
  typedef enum logic [1:0] {
    PH_RD = 2'd0,
    PH_I1 = 2'd1,
    PH_WR = 2'd2,
    PH_I2 = 2'd3
  } phase_e;
endpackage

// File: rtl/lds_seq.sv
module lds_seq
  import lds_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] num_steps,
  input  logic          bus_free,
  output phase_e        phase,
  output logic          active,
  output logic          first,
  output logic          done,
  output logic          load,
  output logic          wr_grant
);
  logic [CW-1:0] remain;

  assign load     = start && !active;
  assign wr_grant = active && (phase == PH_WR) && bus_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= PH_RD;
      remain <= '0;
      first  <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      phase  <= PH_RD;
      remain <= num_steps;
      first  <= 1'b1;
      if (num_steps == '0) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        active <= 1'b1;
        done   <= 1'b0;
      end
    end else if (active) begin
      case (phase)
        PH_RD: if (bus_free) phase <= PH_I1;
        PH_I1: phase <= PH_WR;
        PH_WR: if (bus_free) begin
          phase  <= PH_I2;
          remain <= remain - 1'b1;
          first  <= 1'b0;
        end
        default: begin
          phase <= PH_RD;
          if (remain == '0) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      endcase
    end
  end

  // R8: while a line runs the block never shows done
  assert_busy_not_done_R8: assert property (@(posedge clk) disable iff (rst)
    (active && !load) |=> (!done || !active));
endmodule

// File: rtl/lds_ptr.sv
module lds_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] c_init,
  input  logic [AW-1:0] d_init,
  input  logic [AW-1:0] a_init,
  input  logic [AW-1:0] c_mod,
  input  logic [AW-1:0] a_inc,
  input  logic          a_en,
  input  logic          row_step,
  input  logic          word_step,
  input  logic          word_dec,
  output logic [AW-1:0] c_ptr,
  output logic [AW-1:0] d_ptr,
  output logic [AW-1:0] a_ptr
);
  localparam logic [AW-1:0] WORD_UP   = AW'(1);
  localparam logic [AW-1:0] WORD_DOWN = {AW{1'b1}};

  logic [AW-1:0] row_delta, word_delta;

  always_comb begin
    row_delta  = row_step ? c_mod : '0;
    word_delta = word_step ? (word_dec ? WORD_DOWN : WORD_UP) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_ptr <= '0;
      d_ptr <= '0;
      a_ptr <= '0;
    end else if (load) begin
      c_ptr <= c_init;
      d_ptr <= d_init;
      a_ptr <= a_init;
    end else if (step) begin
      c_ptr <= c_ptr + row_delta + word_delta;
      if (a_en) a_ptr <= a_ptr + a_inc;
    end
  end

  // R6: a disabled A channel freezes the A pointer
  assert_a_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!a_en && !load) |=> $stable(a_ptr));

  // R3: the first-write target never moves during a line
  assert_d_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(d_ptr));
endmodule

// File: rtl/line_addr_seq.sv
module line_addr_seq
  import lds_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 10,
  parameter int HW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] num_steps,
  input  logic [HW-1:0] hsize,
  input  logic [AW-1:0] c_ptr_in,
  input  logic [AW-1:0] d_ptr_in,
  input  logic [AW-1:0] a_ptr_in,
  input  logic [AW-1:0] c_mod,
  input  logic [AW-1:0] d_mod,
  input  logic [AW-1:0] a_inc,
  input  logic          a_en,
  input  logic          d_en,
  input  logic          row_step,
  input  logic          word_step,
  input  logic          word_dec,
  input  logic          bus_free,
  output logic          req_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] a_ptr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          hsize_warn_o
);
  localparam logic [HW-1:0] LINE_HSIZE = HW'(2);

  phase_e        phase;
  logic          active, first, done, load, wr_grant;
  logic [AW-1:0] c_ptr, d_ptr;
  logic          warn_q;

  // line mode ignores the D modulo and D enable
  logic unused_line_cfg;
  assign unused_line_cfg = ^{d_en, d_mod};

  lds_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .num_steps(num_steps),
    .bus_free(bus_free), .phase(phase), .active(active), .first(first),
    .done(done), .load(load), .wr_grant(wr_grant)
  );

  lds_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load(load), .step(wr_grant),
    .c_init(c_ptr_in), .d_init(d_ptr_in), .a_init(a_ptr_in),
    .c_mod(c_mod), .a_inc(a_inc), .a_en(a_en),
    .row_step(row_step), .word_step(word_step), .word_dec(word_dec),
    .c_ptr(c_ptr), .d_ptr(d_ptr), .a_ptr(a_ptr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) warn_q <= 1'b0;
    else if (load) warn_q <= (hsize != LINE_HSIZE);
  end

  assign req_o        = active && ((phase == PH_RD) || (phase == PH_WR));
  assign wr_o         = active && (phase == PH_WR);
  assign addr_o       = ((phase == PH_WR) && first) ? d_ptr : c_ptr;
  assign busy_o       = active;
  assign done_o       = done;
  assign hsize_warn_o = warn_q;

  // R1: granted read -> idle slot -> write request
  assert_idle_after_read_R1: assert property (@(posedge clk) disable iff (rst)
    (req_o && !wr_o && bus_free) |=> !req_o ##1 (req_o && wr_o));

  // R1: granted write -> idle slot
  assert_idle_after_write_R1: assert property (@(posedge clk) disable iff (rst)
    (req_o && wr_o && bus_free) |=> !req_o);

  // R7: refused request stays frozen
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_o && !bus_free) |=> (req_o && $stable(wr_o) && $stable(addr_o)));

  // R8: a finished line is quiet
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!req_o && !busy_o));
endmodule

// File: tb/test_line_addr_seq.sv
module test_line_addr_seq;
  localparam int AW = 16;
  localparam int CW = 10;
  localparam int HW = 6;

  logic          clk = 1'b0;
  logic          rst, start;
  logic [CW-1:0] num_steps;
  logic [HW-1:0] hsize;
  logic [AW-1:0] c_ptr_in, d_ptr_in, a_ptr_in, c_mod, d_mod, a_inc;
  logic          a_en, d_en, row_step, word_step, word_dec, bus_free;
  logic          req_o, wr_o, busy_o, done_o, hsize_warn_o;
  logic [AW-1:0] addr_o, a_ptr_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  line_addr_seq #(.AW(AW), .CW(CW), .HW(HW)) i_line_addr_seq (
    .clk(clk), .rst(rst), .start(start), .num_steps(num_steps), .hsize(hsize),
    .c_ptr_in(c_ptr_in), .d_ptr_in(d_ptr_in), .a_ptr_in(a_ptr_in),
    .c_mod(c_mod), .d_mod(d_mod), .a_inc(a_inc), .a_en(a_en), .d_en(d_en),
    .row_step(row_step), .word_step(word_step), .word_dec(word_dec),
    .bus_free(bus_free), .req_o(req_o), .wr_o(wr_o), .addr_o(addr_o),
    .a_ptr_o(a_ptr_o), .busy_o(busy_o), .done_o(done_o),
    .hsize_warn_o(hsize_warn_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_line(input int n, input bit aen, input bit den,
                          input bit pat, input logic [HW-1:0] hs, input int seed);
    logic [AW-1:0] mc, exp_a, d0;
    int k, st, guard;
    bit r, w, dc;
    @(negedge clk);
    c_ptr_in  = AW'(16'h1000 + seed * 37);
    d_ptr_in  = AW'(16'h4000 + seed * 11);
    a_ptr_in  = AW'(16'h2000 + seed);
    c_mod     = (seed % 2 == 1) ? 16'hFFD8 : 16'd40;
    d_mod     = AW'(16'h0123 ^ seed);
    a_inc     = ((seed / 2) % 2 == 1) ? 16'hFFFE : 16'h0003;
    a_en      = aen;
    d_en      = den;
    hsize     = hs;
    num_steps = CW'(n);
    bus_free  = 1'b1;
    start     = 1'b1;
    mc = c_ptr_in;
    d0 = d_ptr_in;
    exp_a = a_ptr_in + (aen ? AW'(n) * a_inc : '0);
    @(negedge clk);
    start = 1'b0;
    chk(hsize_warn_o == (hs != HW'(2)), "R9 hsize warning", hsize_warn_o, hs != HW'(2));
    k = 0;
    st = (n == 0) ? 4 : 0;
    guard = 0;
    while (st != 4 && guard < 2000) begin
      guard++;
      r  = ((k + seed) % 3) != 0;
      w  = ((k + seed) % 2) == 0;
      dc = (((k / 2) ^ seed) % 2) == 1;
      row_step  = r;
      word_step = w;
      word_dec  = dc;
      bus_free  = pat ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      case (st)
        0: begin
          chk(req_o && !wr_o && addr_o == mc, "R2 R7 read request",
              {req_o, wr_o, addr_o}, {2'b10, mc});
          if (bus_free) st = 1;
        end
        1: begin
          chk(!req_o && busy_o, "R1 R7 idle after read", {req_o, busy_o}, 2'b01);
          st = 2;
        end
        2: begin
          chk(req_o && wr_o && addr_o == ((k == 0) ? d0 : mc),
              (k == 0) ? "R3 R5 first write to D" : "R3 R4 R5 later write to C",
              {req_o, wr_o, addr_o}, {2'b11, ((k == 0) ? d0 : mc)});
          if (bus_free) begin
            mc = mc + (r ? c_mod : '0) + (w ? (dc ? 16'hFFFF : 16'h0001) : '0);
            k++;
            st = 3;
          end
        end
        default: begin
          chk(!req_o && busy_o, "R1 R7 idle after write", {req_o, busy_o}, 2'b01);
          st = (k == n) ? 4 : 0;
        end
      endcase
      @(negedge clk);
    end
    chk(guard < 2000, "R8 line completes", guard, 2000);
    #1;
    chk(done_o && !busy_o && !req_o, "R8 done after last step",
        {done_o, busy_o, req_o}, 3'b100);
    chk(a_ptr_o == exp_a, "R6 A pointer final value", a_ptr_o, exp_a);
    @(negedge clk);
    #1;
    chk(done_o && !req_o, "R8 done held", {done_o, req_o}, 2'b10);
    chk(hsize_warn_o == (hs != HW'(2)), "R9 warning held", hsize_warn_o, hs != HW'(2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    logic [HW-1:0] hs;
    rst = 1'b1; start = 1'b0; num_steps = '0; hsize = HW'(2);
    c_ptr_in = '0; d_ptr_in = '0; a_ptr_in = '0; c_mod = '0; d_mod = '0;
    a_inc = '0; a_en = 1'b0; d_en = 1'b0; row_step = 1'b0; word_step = 1'b0;
    word_dec = 1'b0; bus_free = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!req_o && !busy_o && !done_o && !hsize_warn_o, "R8 reset state",
        {req_o, busy_o, done_o, hsize_warn_o}, 4'b0000);
    rst = 1'b0;
    seed = 0;
    for (int n = 0; n <= 5; n++)
      for (int ae = 0; ae < 2; ae++)
        for (int de = 0; de < 2; de++)
          for (int p = 0; p < 2; p++)
            for (int h = 0; h < 3; h++) begin
              hs = (h == 0) ? HW'(2) : ((h == 1) ? HW'(1) : HW'(3));
              run_line(n, ae[0], de[0], p[0], hs, seed);
              seed++;
            end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule